// File: doc/BRIEF.md
# Byte-Lane Memory Transfer Engine

This block copies a run of words between an 8-bit external byte memory and an internal word memory. The transfer works one byte at a time. On a load, bytes read from the external side are packed into internal words. On a store, internal words are split into bytes that go out on the byte lane. A 2-bit format code sets the internal word shape:

- a 24-bit program word built from three bytes;
- a 16-bit data word built from two bytes;
- a single byte placed in the upper half of a data word, with the rest zero-filled;
- a single byte placed in the lower half of a data word, with the rest zero-filled.

Software first programs the control, page, external offset, internal address and wait-state registers. It then writes the word count, and that write starts the transfer. During the transfer the block drives:

- the 14-bit external offset on the address pins;
- the 8-bit page on the upper byte of the external data bus;
- the byte itself on the middle byte of that bus.

Together, page and offset form a 22-bit byte address that advances after every byte. For each completed word the block requests exactly one internal memory cycle and holds the request until it sees a grant. A control bit decides whether the processor is told to halt while the transfer runs. A single-cycle done pulse marks the end of the transfer.

Top module: `byte_dma_engine`

## Requirements
- R1: The external byte address is {page[7:0], offset[13:0]}. The offset appears on `ext_addr` and the page on `ext_dout[23:16]` during every byte access. The address increments after each byte, the offset carries into the page when it passes 0x3FFF, and page 0xFF with offset 0x3FFF wraps to zero. `ext_dout` is zero when no access is active.
- R2: Format 0 (load): three bytes are read most significant first and written as one 24-bit word with `mem_pm`=1.
- R3: Format 1 (load): two bytes are read most significant first and written as {8'h00, first, second} with `mem_pm`=0.
- R4: Format 2 (load) writes {8'h00, byte, 8'h00}. Format 3 (load) writes {16'h0000, byte}. Both use `mem_pm`=0.
- R5: In direction 1 (store), each word is first read from internal memory and then sent most significant byte first on `ext_dout[15:8]`. The bytes sent are: format 0 all three bytes; format 1 bits 15:8 then 7:0; format 2 bits 15:8; format 3 bits 7:0.
- R6: Each byte access holds `ext_rd` (load) or `ext_wr` (store) high for exactly wait+1 cycles, with a stable address. Accesses follow one another with no gap.
- R7: Each word uses one internal cycle. `mem_req` stays high, with `mem_addr` and `mem_we` stable, until the cycle in which `mem_gnt` is high. `mem_addr` increments by one per word. A load writes (`mem_we`=1) after its last byte. A store reads (`mem_we`=0) before its first byte, taking `mem_rdata` in the grant cycle.
- R8: Writes use `reg_sel`: 0 = control {halt[3], dir[2], fmt[1:0]}, 1 = page, 2 = offset, 3 = internal address, 4 = wait count, 5 = word count. A nonzero word-count write while idle starts the transfer, so `busy` is high in the next cycle. A zero count does not start a transfer.
- R9: `done` is high for exactly one cycle. That cycle follows the completion of the last word, which is the last grant for a load and the last byte for a store. `busy` is low in that same cycle.
- R10: Register writes of any kind while `busy` is high have no effect on the running transfer.
- R11: `core_halt` equals `busy` when the halt bit is 1, and stays 0 otherwise.
- R12: After reset the block is idle: `busy`, `done`, `core_halt`, `mem_req`, `ext_rd`, `ext_wr` and `ext_dout` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 14 | Register write data |
| ext_addr | output | 14 | External byte offset |
| ext_dout | output | 24 | External data bus out: page on 23:16, byte on 15:8 |
| ext_din | input | 8 | External byte lane in (bus bits 15:8) |
| ext_rd | output | 1 | External read strobe |
| ext_wr | output | 1 | External write strobe |
| mem_req | output | 1 | Internal memory cycle request |
| mem_gnt | input | 1 | Internal memory cycle grant |
| mem_we | output | 1 | Internal write (1) or read (0) |
| mem_pm | output | 1 | Internal cycle targets program memory |
| mem_addr | output | IADDR_W | Internal word address |
| mem_wdata | output | 24 | Internal write data |
| mem_rdata | input | 24 | Internal read data, valid in the grant cycle |
| busy | output | 1 | Transfer active |
| done | output | 1 | One-cycle completion pulse |
| core_halt | output | 1 | Processor halt request |

## Verification
The start of a transfer is visible in the first cycle after the edge that captures the count write. After that, each byte strobe is due for wait+1 cycles, and each memory request lasts until the edge that sees the grant. The done pulse comes one cycle after the final word completes. The bench model walks through this schedule in the same order, one clock at a time. It sets the expected state of every output for the coming cycle and compares at the falling edge, half a period away from the edge that changes them. In this way the bench checks the timing of the strobes, the request and the done pulse, and not only the data moved.

// File: rtl/byte_dma_engine.sv
module byte_dma_engine #(
  parameter int IADDR_W = 14,
  parameter int WAIT_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [2:0]         reg_sel,
  input  logic [13:0]        reg_wdata,
  output logic [13:0]        ext_addr,
  output logic [23:0]        ext_dout,
  input  logic [7:0]         ext_din,
  output logic               ext_rd,
  output logic               ext_wr,
  output logic               mem_req,
  input  logic               mem_gnt,
  output logic               mem_we,
  output logic               mem_pm,
  output logic [IADDR_W-1:0] mem_addr,
  output logic [23:0]        mem_wdata,
  input  logic [23:0]        mem_rdata,
  output logic               busy,
  output logic               done,
  output logic               core_halt
);
  localparam int OFF_W  = 14;
  localparam int PAGE_W = 8;
  localparam int CNT_W  = 14;
  localparam int XA_W   = OFF_W + PAGE_W;

  typedef enum logic [1:0] {S_IDLE, S_BYTE, S_MEM} state_t;

  state_t              state;
  logic [1:0]          fmt;
  logic                dir, halt_sel, done_r;
  logic [PAGE_W-1:0]   page;
  logic [OFF_W-1:0]    offset;
  logic [IADDR_W-1:0]  iaddr;
  logic [WAIT_W-1:0]   wait_cfg, wt_cnt;
  logic [CNT_W-1:0]    wcount;
  logic [1:0]          byte_idx, last_idx;
  logic [23:0]         shreg, packed_w, unpacked_w;
  logic [XA_W-1:0]     next_xa;
  logic                byte_end;

  assign last_idx = (fmt == 2'd0) ? 2'd2 : (fmt == 2'd1) ? 2'd1 : 2'd0;
  assign byte_end = (state == S_BYTE) && (wt_cnt == wait_cfg);
  assign next_xa  = {page, offset} + XA_W'(1);

  always_comb begin
    case (fmt)
      2'd0:    packed_w = shreg;
      2'd1:    packed_w = {8'h00, shreg[15:0]};
      2'd2:    packed_w = {8'h00, shreg[7:0], 8'h00};
      default: packed_w = {16'h0000, shreg[7:0]};
    endcase
    case (fmt)
      2'd0:    unpacked_w = mem_rdata;
      2'd1:    unpacked_w = {mem_rdata[15:0], 8'h00};
      2'd2:    unpacked_w = {mem_rdata[15:8], 16'h0000};
      default: unpacked_w = {mem_rdata[7:0], 16'h0000};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      fmt      <= '0;
      dir      <= 1'b0;
      halt_sel <= 1'b0;
      page     <= '0;
      offset   <= '0;
      iaddr    <= '0;
      wait_cfg <= '0;
      wt_cnt   <= '0;
      wcount   <= '0;
      byte_idx <= '0;
      shreg    <= '0;
      done_r   <= 1'b0;
    end else begin
      done_r <= 1'b0;
      case (state)
        S_IDLE: if (reg_we) begin
          case (reg_sel)
            3'd0: {halt_sel, dir, fmt} <= reg_wdata[3:0];
            3'd1: page     <= reg_wdata[PAGE_W-1:0];
            3'd2: offset   <= reg_wdata[OFF_W-1:0];
            3'd3: iaddr    <= reg_wdata[IADDR_W-1:0];
            3'd4: wait_cfg <= reg_wdata[WAIT_W-1:0];
            3'd5: if (reg_wdata[CNT_W-1:0] != '0) begin
              wcount   <= reg_wdata[CNT_W-1:0];
              byte_idx <= '0;
              wt_cnt   <= '0;
              state    <= dir ? S_MEM : S_BYTE;
            end
            default: ;
          endcase
        end
        S_BYTE: begin
          if (byte_end) begin
            wt_cnt           <= '0;
            {page, offset}   <= next_xa;
            shreg            <= dir ? {shreg[15:0], 8'h00} : {shreg[15:0], ext_din};
            if (byte_idx == last_idx) begin
              byte_idx <= '0;
              if (!dir)
                state <= S_MEM;
              else if (wcount == '0) begin
                state  <= S_IDLE;
                done_r <= 1'b1;
              end else
                state <= S_MEM;
            end else
              byte_idx <= byte_idx + 2'd1;
          end else
            wt_cnt <= wt_cnt + WAIT_W'(1);
        end
        S_MEM: if (mem_gnt) begin
          iaddr  <= iaddr + IADDR_W'(1);
          wcount <= wcount - CNT_W'(1);
          if (dir) begin
            shreg <= unpacked_w;
            state <= S_BYTE;
          end else if (wcount == CNT_W'(1)) begin
            state  <= S_IDLE;
            done_r <= 1'b1;
          end else
            state <= S_BYTE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign ext_addr  = offset;
  assign ext_rd    = (state == S_BYTE) && !dir;
  assign ext_wr    = (state == S_BYTE) && dir;
  assign ext_dout  = (state == S_BYTE) ? {page, (dir ? shreg[23:16] : 8'h00), 8'h00} : 24'h0;
  assign mem_req   = (state == S_MEM);
  assign mem_we    = (state == S_MEM) && !dir;
  assign mem_pm    = (fmt == 2'd0);
  assign mem_addr  = iaddr;
  assign mem_wdata = dir ? 24'h0 : packed_w;
  assign busy      = (state != S_IDLE);
  assign done      = done_r;
  assign core_halt = busy && halt_sel;

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  // R8
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && reg_we && reg_sel == 3'd5 && reg_wdata != 14'd0 |=> busy);
  // R8
  zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && reg_we && reg_sel == 3'd5 && reg_wdata == 14'd0 |=> !busy);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy ##1 !done);
  // R10
  busy_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && reg_we && reg_sel == 3'd3 && !(mem_req && mem_gnt) |=> $stable(mem_addr));
  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ext_rd && ext_wr));
endmodule

// File: tb/byte_dma_engine_test.sv
`timescale 1ns/1ps
module byte_dma_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [13:0] reg_wdata = '0;
  logic [13:0] ext_addr;
  logic [23:0] ext_dout;
  logic [7:0]  ext_din;
  logic        ext_rd, ext_wr, mem_req, mem_we, mem_pm, busy, done, core_halt;
  logic        mem_gnt = 1'b0;
  logic [13:0] mem_addr;
  logic [23:0] mem_wdata, mem_rdata;

  int vectors = 0;
  int miscompares = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] bval(logic [21:0] a);
    return a[7:0] ^ a[15:8] ^ {a[21:16], 2'b10} ^ 8'h3C;
  endfunction
  function automatic logic [23:0] rfun(logic [13:0] a);
    return {a[7:0] ^ 8'h96, a[7:0] + 8'h3B, ~a[7:0]};
  endfunction

  assign ext_din   = bval({ext_dout[23:16], ext_addr});
  assign mem_rdata = rfun(mem_addr);

  byte_dma_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .ext_addr(ext_addr), .ext_dout(ext_dout), .ext_din(ext_din), .ext_rd(ext_rd),
    .ext_wr(ext_wr), .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we),
    .mem_pm(mem_pm), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .core_halt(core_halt));

  logic        e_rd, e_wr, e_req, e_we, e_pm, e_busy, e_done, e_halt, e_wdchk;
  logic [13:0] e_addr, e_maddr;
  logic [7:0]  e_page, e_byte;
  logic [23:0] e_wd;

  task automatic expect_idle(logic d);
    e_rd = 0; e_wr = 0; e_req = 0; e_we = 0; e_pm = 0; e_busy = 0;
    e_done = d; e_halt = 0; e_wdchk = 0;
  endtask

  function automatic bit cmp(string tag, string what, int act, int exp);
    if (act != exp) begin
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic step(string tag);
    bit bad = 0;
    vectors++;
    bad |= cmp(tag, "ext_rd", ext_rd, e_rd);
    bad |= cmp(tag, "ext_wr", ext_wr, e_wr);
    bad |= cmp(tag, "mem_req", mem_req, e_req);
    bad |= cmp(tag, "busy", busy, e_busy);
    bad |= cmp(tag, "done", done, e_done);
    bad |= cmp(tag, "core_halt", core_halt, e_halt);
    if (e_rd || e_wr) begin
      bad |= cmp(tag, "ext_addr", ext_addr, e_addr);
      bad |= cmp(tag, "page", ext_dout[23:16], e_page);
      bad |= cmp(tag, "low lane", ext_dout[7:0], 0);
      if (e_wr) bad |= cmp(tag, "byte", ext_dout[15:8], e_byte);
    end else if (!e_req) begin
      bad |= cmp(tag, "ext_dout idle", ext_dout, 0);
    end
    if (e_req) begin
      bad |= cmp(tag, "mem_we", mem_we, e_we);
      bad |= cmp(tag, "mem_pm", mem_pm, e_pm);
      bad |= cmp(tag, "mem_addr", mem_addr, e_maddr);
      if (e_wdchk) bad |= cmp(tag, "mem_wdata", mem_wdata, e_wd);
    end
    if (bad) miscompares++;
    @(negedge clk);
  endtask

  task automatic wr(logic [2:0] s, logic [13:0] d);
    reg_we = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic run(string tag, logic dir, logic [1:0] fmt, logic halt, logic [7:0] pg,
                     logic [13:0] off, logic [13:0] ia, int wt, int cnt, int gd, bit inj);
    logic [21:0] xa = {pg, off};
    logic [23:0] acc = '0;
    logic [23:0] al = '0;
    int n = (fmt == 0) ? 3 : (fmt == 1) ? 2 : 1;
    int st = 0;
    wr(0, {10'd0, halt, dir, fmt});
    wr(1, {6'd0, pg});
    wr(2, off);
    wr(3, ia);
    wr(4, 14'(wt));
    wr(5, 14'(cnt));
    for (int w = 0; w < cnt; w++) begin
      if (dir) begin
        for (int g = 0; g <= gd; g++) begin
          mem_gnt = (g == gd);
          expect_idle(0);
          e_req = 1; e_we = 0; e_pm = (fmt == 0); e_maddr = ia; e_busy = 1; e_halt = halt;
          if (inj && st == 0) begin reg_we = 1; reg_sel = 5; reg_wdata = 14'd3; end
          else if (inj && st == 1) begin reg_we = 1; reg_sel = 2; reg_wdata = 14'h0; end
          else reg_we = 0;
          st++;
          step(tag);
        end
        case (fmt)
          2'd0: al = rfun(ia);
          2'd1: al = {rfun(ia)[15:0], 8'h00};
          2'd2: al = {rfun(ia)[15:8], 16'h0};
          default: al = {rfun(ia)[7:0], 16'h0};
        endcase
        ia++;
      end
      for (int b = 0; b < n; b++) begin
        for (int k = 0; k <= wt; k++) begin
          mem_gnt = 0;
          expect_idle(0);
          e_rd = !dir; e_wr = dir; e_addr = xa[13:0]; e_page = xa[21:14];
          e_byte = al[23 - 8*b -: 8]; e_busy = 1; e_halt = halt;
          if (inj && st == 0) begin reg_we = 1; reg_sel = 5; reg_wdata = 14'd3; end
          else if (inj && st == 1) begin reg_we = 1; reg_sel = 2; reg_wdata = 14'h0; end
          else reg_we = 0;
          st++;
          step(tag);
        end
        acc = {acc[15:0], bval(xa)};
        xa++;
      end
      if (!dir) begin
        for (int g = 0; g <= gd; g++) begin
          mem_gnt = (g == gd);
          expect_idle(0);
          e_req = 1; e_we = 1; e_pm = (fmt == 0); e_maddr = ia; e_busy = 1; e_halt = halt;
          e_wdchk = 1;
          case (fmt)
            2'd0: e_wd = acc;
            2'd1: e_wd = {8'h00, acc[15:0]};
            2'd2: e_wd = {8'h00, acc[7:0], 8'h00};
            default: e_wd = {16'h0, acc[7:0]};
          endcase
          reg_we = 0;
          step(tag);
        end
        ia++;
      end
    end
    mem_gnt = 0;
    reg_we = 0;
    expect_idle(1);
    step({tag, " R9 done"});
    expect_idle(0);
    step({tag, " R9 after"});
  endtask

  initial begin
    #1_000_000;
    miscompares++;
    $display("FAIL R9 watchdog: actual hung expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
    expect_idle(0);
    for (int i = 0; i < 3; i++) step("R12 reset");
    run("R1 R2 R6 R7 R8 load fmt0 page carry", 0, 2'd0, 0, 8'h05, 14'h3FFE, 14'h010, 0, 2, 0, 0);
    run("R3 R11 load fmt1 halt", 0, 2'd1, 1, 8'h21, 14'h0100, 14'h200, 2, 2, 2, 0);
    run("R4 load fmt2", 0, 2'd2, 0, 8'h40, 14'h1234, 14'h030, 1, 3, 1, 0);
    run("R4 load fmt3", 0, 2'd3, 0, 8'h41, 14'h0FFF, 14'h031, 0, 2, 0, 0);
    run("R5 R1 store fmt0 full wrap", 1, 2'd0, 0, 8'hFF, 14'h3FFE, 14'h3FFF, 1, 2, 1, 0);
    run("R5 store fmt1", 1, 2'd1, 1, 8'h12, 14'h0040, 14'h0400, 0, 2, 0, 0);
    run("R5 store fmt2", 1, 2'd2, 0, 8'h13, 14'h0050, 14'h0500, 2, 2, 3, 0);
    run("R5 store fmt3", 1, 2'd3, 0, 8'h14, 14'h0060, 14'h0600, 0, 3, 0, 0);
    wr(5, 14'd0);
    expect_idle(0);
    for (int i = 0; i < 3; i++) step("R8 zero count");
    run("R10 load writes while busy", 0, 2'd1, 0, 8'h33, 14'h0700, 14'h0080, 1, 2, 0, 1);
    run("R10 store writes while busy", 1, 2'd0, 0, 8'h34, 14'h0800, 14'h0090, 0, 1, 1, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule